// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a 4-Kbit serial EEPROM. It sits on a three-wire serial bus with a chip select, a serial clock and a data input. It answers on a data output that has its own output enable. A mode input chooses whether the 4096-bit array is seen as 512 bytes or as 256 sixteen-bit words. The serial pins are sampled with the block's own system clock, and a rising edge of the serial clock is detected inside the block.

Each transaction is framed by the chip select. The master sends a start bit, an opcode and an address, all MSB first. The block then does one of several things: it streams entries out, it takes in data for a program operation, or it changes the write-enable state. A program operation runs for a fixed number of system clock cycles and does not need the serial clock to keep running. While it runs, a master that raises the chip select sees the busy or ready state on the data output.

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset, writes are disabled, the output enable is low, and every entry reads as all ones.
- R2: A frame starts with a 1 bit, which is followed by a 2-bit opcode and then the address, all sampled on rising serial clock edges with the MSB first. The address is 9 bits when wide_mode=0 (byte entries) and 8 bits when wide_mode=1 (16-bit entries).
- R3: Opcode 10 is a read. On the rising edge that samples the last address bit, the data output drives a 0. Each of the following rising edges then presents one data bit, MSB first. In byte mode, byte address 2k+1 is the upper half of word k and 2k is the lower half.
- R4: While the chip select stays high, a read goes on with the next entry, with no extra 0 bit in between. After the highest address it continues at address 0.
- R5: Opcode 00 with address MSBs 11 enables writes, and with MSBs 00 it disables them. While writes are disabled, write (01), erase (11), erase-all (00 with MSBs 10) and write-all (00 with MSBs 01) change nothing and start no program cycle.
- R6: A write stores one whole entry (8 or 16 data bits follow the address), whatever the entry held before. An erase sets one entry to all ones. Erase-all sets every entry to all ones. Write-all copies the data into every entry.
- R7: A program cycle lasts PROG_CYCLES system clocks and needs no serial clock activity. While the chip select is high and no frame is active, the output is enabled and shows 0 while the cycle runs and 1 once it is done.
- R8: A start bit that arrives while a program cycle is running is ignored, and so is the rest of that frame.
- R9: A low chip select aborts any frame and disables the output. The next frame is decoded from its start bit.
- R10: Zero bits that come before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins and times the program cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Active-high chip select |
| ser_clk | input | 1 | Serial clock; bits are taken on its rising edge |
| ser_in | input | 1 | Serial data into the block |
| wide_mode | input | 1 | 1 selects 256 x 16 entries, 0 selects 512 x 8 |
| ser_out | output | 1 | Serial read data or busy/ready status |
| ser_out_en | output | 1 | High while ser_out is driven |

## Verification
The assertions check on every cycle that a program cycle only starts when writes are enabled, that its counter falls by one per clock, that no frame can start while it runs, and that a low chip select leaves the output disabled and the decoder idle. The bench scenarios are the only way to show the data side. They cover the exact bit order of a read and its leading 0, the byte lanes, the address wrap in both organisations, overwriting without an erase, the bulk commands, and the fact that commands sent while the block is locked or busy leave the array untouched.

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model #(
  parameter int PROG_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_sel,
  input  logic ser_clk,
  input  logic ser_in,
  input  logic wide_mode,
  output logic ser_out,
  output logic ser_out_en
);
  localparam int ENTRIES = 256;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = WORD_W / 2;
  localparam int ADDR_W  = $clog2(ENTRIES) + 1;
  localparam int FRAME_W = ADDR_W + 2;
  localparam int IDX_W   = $clog2(FRAME_W + WORD_W);
  localparam int CNT_W   = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_HOLD} state_t;

  logic [WORD_W-1:0]  mem [ENTRIES];
  state_t             st;
  logic               clk_q, wr_en, armed, pall, pwide, obit;
  logic [IDX_W-1:0]   cnt;
  logic [FRAME_W-2:0] sh;
  logic [ADDR_W-1:0]  ptr, pa;
  logic [WORD_W-1:0]  osh, pd;
  logic [CNT_W-1:0]   prog_cnt;

  wire rise = ser_clk & ~clk_q;
  wire busy = prog_cnt != '0;
  wire commit = prog_cnt == CNT_W'(1);

  wire [FRAME_W-1:0] fr = {sh, ser_in};
  wire [1:0] op_c  = wide_mode ? fr[FRAME_W-2 -: 2] : fr[FRAME_W-1 -: 2];
  wire [1:0] ext_c = wide_mode ? fr[ADDR_W-2 -: 2]  : fr[ADDR_W-1 -: 2];
  wire [ADDR_W-1:0] ad_c = wide_mode ? {1'b0, fr[ADDR_W-2:0]} : fr[ADDR_W-1:0];
  wire [IDX_W-1:0] frame_last = wide_mode ? IDX_W'(FRAME_W-2) : IDX_W'(FRAME_W-1);
  wire [IDX_W-1:0] data_last  = wide_mode ? IDX_W'(WORD_W-1)  : IDX_W'(BYTE_W-1);

  wire frame_end = st == ST_CMD && cnt == frame_last;
  wire go_cmd  = frame_end && wr_en && (op_c == 2'b11 || (op_c == 2'b00 && ext_c == 2'b10));
  wire go_data = st == ST_DATA && cnt == data_last;
  wire go_now  = chip_sel && rise && (go_cmd || go_data);
  wire go_all  = go_cmd ? (op_c == 2'b00) : pall;
  wire [ADDR_W-1:0] go_addr = go_cmd ? ad_c : pa;
  wire [WORD_W-1:0] go_val  = go_cmd ? '1 : {pd[WORD_W-2:0], ser_in};

  function automatic logic [WORD_W-1:0] fetch(input logic [ADDR_W-1:0] a, input logic w);
    logic [WORD_W-1:0] e;
    e = mem[w ? a[ADDR_W-2:0] : a[ADDR_W-1:1]];
    if (w) return e;
    return a[0] ? {e[WORD_W-1:BYTE_W], {BYTE_W{1'b0}}} : {e[BYTE_W-1:0], {BYTE_W{1'b0}}};
  endfunction

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a, input logic w);
    return w ? {1'b0, a[ADDR_W-2:0] + 1'b1} : a + 1'b1;
  endfunction

  assign ser_out_en = chip_sel && (st == ST_READ || (st == ST_IDLE && armed));
  assign ser_out    = (st == ST_READ) ? obit : !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      clk_q    <= 1'b1;
      wr_en    <= 1'b0;
      armed    <= 1'b0;
      pall     <= 1'b0;
      pwide    <= 1'b0;
      obit     <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      ptr      <= '0;
      pa       <= '0;
      osh      <= '0;
      pd       <= '0;
      prog_cnt <= '0;
    end else begin
      clk_q <= ser_clk;
      if (!chip_sel) begin
        st <= ST_IDLE;
      end else if (rise) begin
        unique case (st)
          ST_IDLE: if (ser_in && !busy) begin
            st    <= ST_CMD;
            cnt   <= '0;
            armed <= 1'b0;
          end
          ST_CMD: begin
            sh  <= fr[FRAME_W-2:0];
            cnt <= cnt + 1'b1;
            if (frame_end) begin
              cnt <= '0;
              st  <= ST_HOLD;
              case (op_c)
                2'b10: begin
                  st   <= ST_READ;
                  osh  <= fetch(ad_c, wide_mode);
                  ptr  <= step(ad_c, wide_mode);
                  obit <= 1'b0;
                end
                2'b01: if (wr_en) begin
                  st   <= ST_DATA;
                  pa   <= ad_c;
                  pall <= 1'b0;
                end
                2'b00: case (ext_c)
                  2'b11: wr_en <= 1'b1;
                  2'b00: wr_en <= 1'b0;
                  2'b01: if (wr_en) begin
                    st   <= ST_DATA;
                    pall <= 1'b1;
                  end
                  default: ;
                endcase
                default: ;
              endcase
            end
          end
          ST_DATA: begin
            pd  <= {pd[WORD_W-2:0], ser_in};
            cnt <= cnt + 1'b1;
          end
          ST_READ: begin
            obit <= osh[WORD_W-1];
            if (cnt == data_last) begin
              osh <= fetch(ptr, wide_mode);
              ptr <= step(ptr, wide_mode);
              cnt <= '0;
            end else begin
              osh <= {osh[WORD_W-2:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (go_now) begin
        st       <= ST_HOLD;
        prog_cnt <= CNT_W'(PROG_CYCLES);
        armed    <= 1'b1;
        pall     <= go_all;
        pa       <= go_addr;
        pd       <= go_val;
        pwide    <= wide_mode;
      end else if (busy) begin
        prog_cnt <= prog_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '1;
    end else if (commit) begin
      if (pall) begin
        for (int i = 0; i < ENTRIES; i++) mem[i] <= pwide ? pd : {2{pd[BYTE_W-1:0]}};
      end else if (pwide) begin
        mem[pa[ADDR_W-2:0]] <= pd;
      end else if (pa[0]) begin
        mem[pa[ADDR_W-1:1]][WORD_W-1:BYTE_W] <= pd[BYTE_W-1:0];
      end else begin
        mem[pa[ADDR_W-1:1]][BYTE_W-1:0] <= pd[BYTE_W-1:0];
      end
    end
  end

  p_prog_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en);

  p_prog_countdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($past(prog_cnt) == prog_cnt + 1'b1));

  p_no_start_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && busy) |=> st == ST_IDLE);

  p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |=> st == ST_IDLE);

  p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_sel |-> !ser_out_en);
endmodule

// File: tb/tb_serial_eeprom_model.sv
module tb_serial_eeprom_model;
  localparam int PROG = 300;
  localparam logic [25:0] VEC [6] = '{
    {1'b1, 9'd3,   16'hA5C3},
    {1'b1, 9'd255, 16'h0F0F},
    {1'b0, 9'd0,   16'h005A},
    {1'b0, 9'd511, 16'h00C7},
    {1'b0, 9'd77,  16'h0081},
    {1'b1, 9'd100, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, sdi = 1'b0, wide = 1'b1;
  logic sdo, sdo_en;
  int nchk = 0, nfail = 0;
  logic [15:0] mdl [256];

  always #5 clk = ~clk;

  serial_eeprom_model #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .chip_sel(cs), .ser_clk(sck), .ser_in(sdi),
    .wide_mode(wide), .ser_out(sdo), .ser_out_en(sdo_en)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic q);
    @(negedge clk); sdi = b; sck = 1'b0;
    wait_clk(2);
    sck = 1'b1;
    wait_clk(2);
    q = sdo;
  endtask

  task automatic sel_on;
    @(negedge clk); cs = 1'b1; sck = 1'b0;
    wait_clk(2);
  endtask

  task automatic sel_off;
    @(negedge clk); cs = 1'b0; sck = 1'b0; sdi = 1'b0;
    wait_clk(3);
  endtask

  function automatic logic [15:0] m_rd(input int a);
    if (wide) return mdl[a & 255];
    return (a & 1) ? {8'h00, mdl[(a >> 1) & 255][15:8]} : {8'h00, mdl[(a >> 1) & 255][7:0]};
  endfunction

  task automatic m_wr(input int a, input logic [15:0] d);
    if (wide) mdl[a & 255] = d;
    else if (a & 1) mdl[(a >> 1) & 255][15:8] = d[7:0];
    else mdl[(a >> 1) & 255][7:0] = d[7:0];
  endtask

  task automatic m_fill(input logic [15:0] d);
    for (int i = 0; i < 256; i++) mdl[i] = d;
  endtask

  task automatic send_cmd(input logic [1:0] op, input int addr, output logic q);
    logic [8:0] a;
    a = addr[8:0];
    sbit(1'b1, q); sbit(op[1], q); sbit(op[0], q);
    for (int i = (wide ? 7 : 8); i >= 0; i--) sbit(a[i], q);
  endtask

  task automatic send_data(input logic [15:0] d);
    logic q;
    for (int i = (wide ? 15 : 7); i >= 0; i--) sbit(d[i], q);
  endtask

  task automatic wait_ready(input string tag);
    int cyc;
    cyc = 0;
    sel_on;
    chk(sdo_en && !sdo, {tag, " R7 busy shows 0"}, {14'd0, sdo_en, sdo}, 16'h0002);
    while (!(sdo_en && sdo) && cyc < 4 * PROG) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc >= PROG - 20 && cyc <= PROG, {tag, " R7 program length"}, 16'(cyc), 16'(PROG));
    sel_off;
  endtask

  task automatic write_entry(input int a, input logic [15:0] d, input string tag);
    logic q;
    sel_on; send_cmd(2'b01, a, q); send_data(d); sel_off;
    m_wr(a, d);
    wait_ready(tag);
  endtask

  task automatic locked_write(input int a, input logic [15:0] d, input string tag);
    logic q;
    sel_on; send_cmd(2'b01, a, q); send_data(d); sel_off;
    sel_on;
    chk(!sdo_en, {tag, " R5 no program started"}, {15'd0, sdo_en}, 16'h0000);
    sel_off;
  endtask

  task automatic ext_cmd(input logic [1:0] e);
    logic q;
    sel_on; send_cmd(2'b00, wide ? {e, 6'd0} : {e, 7'd0}, q); sel_off;
  endtask

  task automatic read_check(input int a, input int n, input int lead, input string tag);
    logic q;
    logic [15:0] val, exp;
    int size;
    size = wide ? 256 : 512;
    sel_on;
    for (int i = 0; i < lead; i++) sbit(1'b0, q);
    send_cmd(2'b10, a, q);
    chk(q == 1'b0 && sdo_en, {tag, " R3 leading 0"}, {14'd0, sdo_en, q}, 16'h0002);
    for (int k = 0; k < n; k++) begin
      val = '0;
      for (int b = 0; b < (wide ? 16 : 8); b++) begin
        sbit(1'b0, q);
        val = {val[14:0], q};
      end
      exp = m_rd((a + k) % size);
      chk(val == exp, tag, val, exp);
    end
    sel_off;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic q;
    m_fill(16'hFFFF);
    wait_clk(3);
    chk(!sdo_en, "R1 output off in reset", {15'd0, sdo_en}, 16'h0000);
    rst_n = 1'b1;
    wait_clk(2);
    chk(!sdo_en, "R1 output off after reset", {15'd0, sdo_en}, 16'h0000);
    read_check(0, 2, 0, "R1 erased array reads ones");

    locked_write(5, 16'h1234, "R5 power-up lock");
    read_check(5, 1, 0, "R5 locked write left entry");
    ext_cmd(2'b11);

    for (int v = 0; v < 6; v++) begin
      wide = VEC[v][25];
      write_entry(int'(VEC[v][24:16]), VEC[v][15:0], "R6 table write");
      read_check(int'(VEC[v][24:16]), 1, 0, "R2 table readback");
    end

    wide = 1'b1;
    write_entry(40, 16'hF00F, "R6 first write");
    write_entry(40, 16'h0FF0, "R6 overwrite");
    read_check(40, 1, 0, "R6 overwrite without erase");

    write_entry(5, 16'h1234, "R3 lane write");
    wide = 1'b0;
    read_check(10, 2, 0, "R3 byte lanes of word 5");

    wide = 1'b1;
    read_check(254, 4, 0, "R4 word wrap");
    wide = 1'b0;
    read_check(510, 3, 0, "R4 byte wrap");

    wide = 1'b1;
    sel_on; send_cmd(2'b11, 40, q); sel_off;
    m_wr(40, 16'hFFFF);
    wait_ready("R6 erase");
    read_check(40, 1, 0, "R6 erased entry");

    sel_on; send_cmd(2'b01, 60, q); send_data(16'hAAAA); sel_off;
    m_wr(60, 16'hAAAA);
    sel_on; send_cmd(2'b01, 61, q); send_data(16'h5555); sel_off;
    sel_on;
    while (!sdo) @(negedge clk);
    sel_off;
    read_check(60, 2, 0, "R8 frame during busy ignored");

    sel_on; sbit(1'b1, q); sbit(1'b1, q); sbit(1'b0, q); sbit(1'b0, q); sbit(1'b1, q);
    sel_off;
    chk(!sdo_en, "R9 deselect disables output", {15'd0, sdo_en}, 16'h0000);
    read_check(3, 1, 0, "R9 frame after aborted frame");
    sel_on; send_cmd(2'b10, 100, q); sbit(1'b0, q); sbit(1'b0, q); sel_off;
    read_check(255, 1, 0, "R9 frame after aborted read");

    read_check(3, 1, 3, "R10 leading zeros ignored");

    sel_on; send_cmd(2'b00, 9'b010000000, q); sel_off;
    m_fill(16'hFFFF);
    wait_ready("R6 erase all");
    read_check(254, 3, 0, "R6 erase all");

    wide = 1'b0;
    sel_on; send_cmd(2'b00, 9'b010000000, q); send_data(16'h003C); sel_off;
    m_fill(16'h3C3C);
    wait_ready("R6 write all");
    wide = 1'b1;
    read_check(17, 2, 0, "R6 write all");

    ext_cmd(2'b00);
    locked_write(9, 16'h7777, "R5 after disable");
    read_check(9, 1, 0, "R5 disabled write left entry");
    sel_on; send_cmd(2'b11, 9, q); sel_off;
    read_check(9, 1, 0, "R5 disabled erase left entry");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule